// File: doc/BRIEF.md
# Centre-Spread Clock Modulation Profile Generator

This block is a synchronous controller that runs on the reference clock and produces a signed frequency-offset word for a downstream digitally synthesized clock (a fractional divider or a phase accumulator). The offset is expressed in units of 1/65536 of the centre frequency. The word sweeps symmetrically above and below zero, so the synthesized clock is spread around its nominal frequency and the peak radiated energy at the fundamental and its harmonics drops. A one-cycle strobe marks every update of the word.

The sweep is not a linear triangle. The offset changes slowly while it is near zero and quickly as it nears either extreme. The shape comes from a computed quarter-wave table that is mirrored to make a full period and scaled by a right shift. Each spread setting doubles the one below it. The period length is a range-dependent number of reference cycles. When modulation is disabled, the word rests at the upper extreme. A power-down request freezes the generator. Changes to range or spread take effect only at the next period boundary.

Top module: `ssc_profile_gen`

## Requirements
- R1: A synchronous active-high reset sets the offset to +409, the strobe to 0 and the sweep position to the start of a period, with active range code 00 and active spread code 00.
- R2: The range code selects the period length P in reference cycles: 00 gives 750, 01 gives 1500, and both 10 and 11 give 3000. A period holds exactly 256 table steps. Counting n cycles from the start of a sweep, a step happens on cycle n whenever floor(256*n/P) grows, so that exactly 256 strobes fall in every P cycles.
- R3: The spread code selects the peak offset magnitude: 00 gives 409, 01 gives 819, 10 gives 1638 and 11 gives 3277. These are the half spreads of 1.25, 2.5, 5 and 10 percent total spread. Every table magnitude is shifted right by (3 - code).
- R4: The offset for sweep position s (0..255) with q = s/64 and k = s%64 is computed as follows. The table value is M(i) = ((2i+1)^2 * 3277 + 8064) / 16129 in integer division, shifted as in R3. For q=0 the offset is +M(63-k), for q=1 it is -M(k), for q=2 it is -M(63-k), and for q=3 it is +M(k).
- R5: While the modulation-disable input is high and power-down is low, each cycle loads the range and spread inputs, returns the position to 0, clears the cycle accumulator and gives no strobe. One cycle later the offset is the positive peak for the spread input.
- R6: Once modulation is enabled, the first step moves the offset below the positive peak, so the sweep heads downward first.
- R7: Within the first quarter of a period, the change per step near the extreme is larger than the change per step near zero.
- R8: While power-down is high, the position, the accumulator, the active settings and the offset all hold, and no strobe is produced. Power-down takes priority over the disable input.
- R9: Range and spread inputs that change while the sweep runs are taken into use only when the position wraps from 255 to 0. The period in progress keeps its old length and its old peak.
- R10: The strobe is high for exactly the one cycle in which the offset takes the value of a new sweep position. The offset never changes without a strobe, except when it is loaded while modulation is disabled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| range_sel | input | 2 | Range code setting the period length |
| spread_sel | input | 2 | Spread code setting the peak offset |
| mod_en_n | input | 1 | Active-low modulation enable; high parks the offset at the upper extreme |
| pwr_dn | input | 1 | Power-down request; freezes the generator |
| offset_o | output | 16 | Signed offset in units of 1/65536 of the centre frequency |
| step_stb_o | output | 1 | One-cycle strobe on each new offset value |

## Verification
The sweep runs at the highest spread, and the strobes and offsets are recorded across a whole period. This shows the strobe count per period, the first downward move, the steeper slope near the extremes and the exact peak and trough. Each range code is then timed from a parked start, which separates the three period lengths and the aliasing of code 11 onto the high range. A settings change in the middle of a period checks that the old length and peak last until the wrap. Power-down bursts and a pseudo-random mix of enable and power-down toggles are compared against a behavioural model on every clock, which catches ordering mistakes between parking, freezing and stepping.

// File: rtl/ssc_pkg.sv
package ssc_pkg;

    localparam int QDEPTH     = 64;
    localparam int QBITS      = $clog2(QDEPTH);
    localparam int PHASE_BITS = QBITS + 2;
    localparam int STEP_INC   = 1 << PHASE_BITS;
    localparam int OFS_W      = 16;
    localparam int PEAK       = 3277;
    localparam int MAG_W      = $clog2(PEAK + 1);
    localparam int DEN        = (2 * QDEPTH - 1) * (2 * QDEPTH - 1);
    localparam int PER_LO     = 750;
    localparam int PER_MID    = 1500;
    localparam int PER_HI     = 3000;
    localparam int ACC_W      = $clog2(PER_HI + STEP_INC);

    typedef enum logic [1:0] {
        RNG_LOW      = 2'd0,
        RNG_MID      = 2'd1,
        RNG_HIGH     = 2'd2,
        RNG_HIGH_ALT = 2'd3
    } rng_e;

    typedef enum logic [1:0] {
        Q_FALL_HI = 2'd0,
        Q_FALL_LO = 2'd1,
        Q_RISE_LO = 2'd2,
        Q_RISE_HI = 2'd3
    } quad_e;

    typedef struct packed {
        logic [1:0] spread;
        rng_e       range;
    } mod_cfg_t;

    function automatic logic [ACC_W-1:0] period_of(rng_e r);
        case (r)
            RNG_LOW: return ACC_W'(PER_LO);
            RNG_MID: return ACC_W'(PER_MID);
            default: return ACC_W'(PER_HI);
        endcase
    endfunction

    function automatic int quarter_mag(int k);
        return ((2 * k + 1) * (2 * k + 1) * PEAK + DEN / 2) / DEN;
    endfunction

endpackage

// File: rtl/ssc_step_timer.sv
module ssc_step_timer
    import ssc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic clr_i,
    input  logic run_i,
    input  rng_e range_i,
    output logic step_o
);

    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] sum;
    logic [ACC_W-1:0] per;

    always_comb begin
        per    = period_of(range_i);
        sum    = acc_q + ACC_W'(STEP_INC);
        step_o = run_i && (sum >= per);
    end

    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            acc_q <= '0;
        end else if (run_i) begin
            acc_q <= step_o ? (sum - per) : sum;
        end
    end

    assert_acc_below_period_R2: assert property (
        @(posedge clk) disable iff (rst) acc_q < per
    );

endmodule

// File: rtl/ssc_phase_ctrl.sv
module ssc_phase_ctrl
    import ssc_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  clr_i,
    input  logic                  step_i,
    input  mod_cfg_t              cfg_in_i,
    output logic [PHASE_BITS-1:0] phase_o,
    output mod_cfg_t              cfg_o
);

    logic [PHASE_BITS-1:0] phase_q;
    mod_cfg_t              cfg_q;
    logic                  wrap;

    assign wrap = step_i && (phase_q == '1);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= '0;
            cfg_q   <= '{spread: 2'b00, range: RNG_LOW};
        end else if (clr_i) begin
            phase_q <= '0;
            cfg_q   <= cfg_in_i;
        end else if (step_i) begin
            phase_q <= phase_q + 1'b1;
            if (wrap) begin
                cfg_q <= cfg_in_i;
            end
        end
    end

    assign phase_o = phase_q;
    assign cfg_o   = cfg_q;

    assert_phase_advance_R2: assert property (
        @(posedge clk) disable iff (rst)
        !$stable(phase_q) |-> (phase_q == $past(phase_q) + 1'b1) || (phase_q == '0)
    );

    assert_cfg_at_boundary_R9: assert property (
        @(posedge clk) disable iff (rst)
        !$stable(cfg_q) |-> ($past(clr_i) || $past(wrap))
    );

endmodule

// File: rtl/ssc_profile_map.sv
module ssc_profile_map
    import ssc_pkg::*;
(
    input  logic [PHASE_BITS-1:0]   phase_i,
    input  logic [1:0]              spread_i,
    output logic signed [OFS_W-1:0] offset_o
);

    logic [MAG_W-1:0] rom [QDEPTH];

    for (genvar g = 0; g < QDEPTH; g++) begin : g_rom
        assign rom[g] = MAG_W'(quarter_mag(g));
    end

    quad_e            quad;
    logic [QBITS-1:0] k;
    logic [QBITS-1:0] idx;
    logic [MAG_W-1:0] mag;
    logic [OFS_W-1:0] ext;
    logic             neg;

    always_comb begin
        quad = quad_e'(phase_i[PHASE_BITS-1:QBITS]);
        k    = phase_i[QBITS-1:0];
        idx  = ((quad == Q_FALL_HI) || (quad == Q_RISE_LO)) ? ~k : k;
        neg  = (quad == Q_FALL_LO) || (quad == Q_RISE_LO);
        mag  = rom[idx] >> (2'd3 - spread_i);
        ext  = {{(OFS_W - MAG_W){1'b0}}, mag};
        offset_o = neg ? (~ext + 1'b1) : ext;
    end

    always_comb begin
        assert_mag_in_range_R3: assert (mag <= MAG_W'(PEAK));
    end

endmodule

// File: rtl/ssc_profile_gen.sv
module ssc_profile_gen
    import ssc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        range_sel,
    input  logic [1:0]        spread_sel,
    input  logic              mod_en_n,
    input  logic              pwr_dn,
    output logic signed [15:0] offset_o,
    output logic              step_stb_o
);

    logic                  clr;
    logic                  run;
    logic                  step;
    logic [PHASE_BITS-1:0] phase;
    mod_cfg_t              cfg_in;
    mod_cfg_t              cfg_act;
    logic                  stb_q;

    assign clr    = !pwr_dn && mod_en_n;
    assign run    = !pwr_dn && !mod_en_n;
    assign cfg_in = '{spread: spread_sel, range: rng_e'(range_sel)};

    ssc_step_timer u_timer (
        .clk     (clk),
        .rst     (rst),
        .clr_i   (clr),
        .run_i   (run),
        .range_i (cfg_act.range),
        .step_o  (step)
    );

    ssc_phase_ctrl u_phase (
        .clk      (clk),
        .rst      (rst),
        .clr_i    (clr),
        .step_i   (step),
        .cfg_in_i (cfg_in),
        .phase_o  (phase),
        .cfg_o    (cfg_act)
    );

    ssc_profile_map u_map (
        .phase_i  (phase),
        .spread_i (cfg_act.spread),
        .offset_o (offset_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            stb_q <= 1'b0;
        end else begin
            stb_q <= step;
        end
    end

    assign step_stb_o = stb_q;

    assert_pwr_freeze_R8: assert property (
        @(posedge clk) disable iff (rst)
        pwr_dn |=> ($stable(offset_o) && !step_stb_o)
    );

    assert_park_high_R5: assert property (
        @(posedge clk) disable iff (rst)
        (mod_en_n && !pwr_dn) |=> (!step_stb_o && (offset_o > 0))
    );

    assert_change_needs_strobe_R10: assert property (
        @(posedge clk) disable iff (rst)
        !$stable(offset_o) |-> (step_stb_o || $past(mod_en_n && !pwr_dn))
    );

endmodule

// File: tb/ssc_profile_gen_tb_top.sv
module ssc_profile_gen_tb_top;

    logic              clk = 1'b0;
    logic              rst;
    logic [1:0]        range_sel;
    logic [1:0]        spread_sel;
    logic              mod_en_n;
    logic              pwr_dn;
    logic signed [15:0] offset_o;
    logic              step_stb_o;

    int n_cmp  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    ssc_profile_gen dut_i (
        .clk        (clk),
        .rst        (rst),
        .range_sel  (range_sel),
        .spread_sel (spread_sel),
        .mod_en_n   (mod_en_n),
        .pwr_dn     (pwr_dn),
        .offset_o   (offset_o),
        .step_stb_o (step_stb_o)
    );

    // Behavioural reference model
    int m_acc, m_pos, m_rng, m_spr, m_stb;
    bit started = 0;

    function automatic int period_len(int r);
        if (r == 0) return 750;
        if (r == 1) return 1500;
        return 3000;
    endfunction

    function automatic int exp_ofs(int pos, int sp);
        int q, k, i, m;
        q = pos / 64;
        k = pos % 64;
        i = (q == 0 || q == 2) ? 63 - k : k;
        m = ((2 * i + 1) * (2 * i + 1) * 3277 + 8064) / 16129;
        m = m >>> (3 - sp);
        return (q == 1 || q == 2) ? -m : m;
    endfunction

    always @(posedge clk) begin
        started <= 1'b1;
        if (rst) begin
            m_acc = 0; m_pos = 0; m_rng = 0; m_spr = 0; m_stb = 0;
        end else if (pwr_dn) begin
            m_stb = 0;
        end else if (mod_en_n) begin
            m_acc = 0; m_pos = 0; m_rng = range_sel; m_spr = spread_sel; m_stb = 0;
        end else begin
            m_acc = m_acc + 256;
            if (m_acc >= period_len(m_rng)) begin
                m_acc = m_acc - period_len(m_rng);
                m_stb = 1;
                if (m_pos == 255) begin
                    m_pos = 0; m_rng = range_sel; m_spr = spread_sel;
                end else begin
                    m_pos = m_pos + 1;
                end
            end else begin
                m_stb = 0;
            end
        end
    end

    task automatic chk(string req, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Per-clock comparison against the model (R4, R10)
    always @(negedge clk) begin
        if (started) begin
            chk("R4 offset vs model", int'(offset_o), exp_ofs(m_pos, m_spr));
            chk("R10 strobe vs model", int'(step_stb_o), m_stb);
        end
    end

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic run_count(int n, output int cnt, output int mn, output int mx);
        cnt = 0; mn = 99999; mx = -99999;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (step_stb_o) cnt++;
            if (int'(offset_o) < mn) mn = int'(offset_o);
            if (int'(offset_o) > mx) mx = int'(offset_o);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
        $finish;
    end

    int ofs_q[$];
    int cnt, mn, mx, held;
    int lcg;

    initial begin
        rst = 1'b1; range_sel = 2'b00; spread_sel = 2'b00; mod_en_n = 1'b1; pwr_dn = 1'b0;
        cyc(3);
        chk("R1 reset offset", int'(offset_o), 409);
        chk("R1 reset strobe", int'(step_stb_o), 0);
        rst = 1'b0;

        // R3 / R5: parked peaks per spread code
        spread_sel = 2'b01; cyc(1); chk("R5 park peak code 01", int'(offset_o), 819);
        spread_sel = 2'b10; cyc(1); chk("R3 peak code 10", int'(offset_o), 1638);
        spread_sel = 2'b11; cyc(1); chk("R3 peak code 11", int'(offset_o), 3277);
        spread_sel = 2'b00; cyc(1); chk("R3 peak code 00", int'(offset_o), 409);

        // One low-range period at the widest spread
        spread_sel = 2'b11; cyc(1);
        mod_en_n = 1'b0;
        for (int i = 0; i < 750; i++) begin
            @(negedge clk);
            if (step_stb_o) ofs_q.push_back(int'(offset_o));
        end
        chk("R2 strobes in low period", ofs_q.size(), 256);
        if (ofs_q.size() == 256) begin
            chk("R6 first step below peak", int'(ofs_q[0] < 3277), 1);
            chk("R7 slope extreme > centre",
                int'((ofs_q[0] - ofs_q[1]) > (ofs_q[61] - ofs_q[62])), 1);
            chk("R4 trough at position 128", ofs_q[127], -3277);
            chk("R4 peak after wrap", ofs_q[255], 3277);
        end

        // R9: settings change right after a wrap waits for the next one
        range_sel = 2'b01; spread_sel = 2'b00;
        run_count(750, cnt, mn, mx);
        chk("R9 old length kept", cnt, 256);
        chk("R9 old trough kept", mn, -3277);
        run_count(1500, cnt, mn, mx);
        chk("R9 new length", cnt, 256);
        chk("R9 new trough", mn, -409);

        // R2: high range and its alias
        mod_en_n = 1'b1; range_sel = 2'b10; spread_sel = 2'b10; cyc(1);
        mod_en_n = 1'b0;
        run_count(3000, cnt, mn, mx);
        chk("R2 strobes range 10", cnt, 256);
        chk("R3 trough code 10", mn, -1638);
        mod_en_n = 1'b1; range_sel = 2'b11; cyc(1);
        mod_en_n = 1'b0;
        run_count(2999, cnt, mn, mx);
        chk("R2 range 11 one short", cnt, 255);
        run_count(1, cnt, mn, mx);
        chk("R2 range 11 last step", cnt, 1);

        // R8: power-down freeze, even against the disable input
        cyc(137);
        pwr_dn = 1'b1;
        cyc(1);
        held = int'(offset_o);
        mod_en_n = 1'b1;
        run_count(40, cnt, mn, mx);
        chk("R8 no strobe in power-down", cnt, 0);
        chk("R8 offset held low", mn, held);
        chk("R8 offset held high", mx, held);
        mod_en_n = 1'b0; pwr_dn = 1'b0;
        cyc(200);

        // Pseudo-random mix checked by the model every clock
        lcg = 12345;
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            lcg = (lcg * 1103515245 + 12345) & 32'h7fffffff;
            if ((lcg % 97) == 0) mod_en_n = ~mod_en_n;
            if ((lcg % 53) == 1) pwr_dn = ~pwr_dn;
            if ((lcg % 211) == 2) range_sel = 2'((lcg >> 8) % 2);
            if ((lcg % 89) == 3) spread_sel = 2'(lcg >> 10);
        end

        cyc(2);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
        $finish;
    end

endmodule